// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host processor access to the buffer memory of a network controller through one data port. The host first writes a 16-bit transfer address and a 16-bit byte count into the engine, one byte per register write. Each later strobe on the data port performs one memory access at the current address: a write stores the supplied data, a read returns the stored data one cycle later. The engine then moves the address forward by the access width and lowers the remaining count.

The access width is one byte or one 16-bit little-endian word, chosen by a configuration input. The address follows the receive ring: when it reaches the ring stop page it jumps back to the ring start page. Only two address windows are backed by memory. Reads outside them return all ones, and writes outside them are dropped. When a transfer ends, the engine sets a completion flag in its interrupt status register. It does the same for a transfer of zero length requested by a command write. The interrupt line follows the status register gated by a mask register.

Top module: `rdma_port_engine`

## Requirements
- R1: Register offsets are: 0 command, 1 address low byte, 2 address high byte, 3 count low byte, 4 count high byte, 5 interrupt status, 6 interrupt mask. A write to one byte of the address or the count leaves the other byte unchanged, and every register reads back at its own offset.
- R2: With `cfg_word` low, each data-port access moves one byte and steps by 1. With `cfg_word` high, each access moves a 16-bit word and steps by 2.
- R3: After each access the address grows by the access width. If the result equals `ring_stop_pg`*256, the address becomes `ring_start_pg`*256.
- R4: If the count before an access is at most the access width, the count becomes 0 and status bit 6 (completion) is set. Otherwise the count drops by the width.
- R5: A data-port write while the count is 0 causes no memory write and leaves the address and count unchanged. Data-port reads are not blocked by a zero count.
- R6: Memory is backed only at byte addresses 0 to 31 and 16384 to 49151. Outside these windows a read returns 0xFFFF for a word or 0x00FF for a byte, and a write reaches no memory. The address and count still advance.
- R7: A word access clears address bit 0 and is little-endian: bits 7:0 belong to the even byte. A byte read returns the byte in bits 7:0 with bits 15:8 at zero.
- R8: `dp_rvalid` is high, with the read data on `dp_rdata`, exactly in the cycle after the cycle that holds the read strobe.
- R9: A command write with bit 0 clear and bit 3 or bit 4 set, while the count is 0, sets status bit 6 at the next edge. Nothing is set when bit 0 is set.
- R10: `irq` is high exactly when (status AND mask AND 0x7F) is nonzero. A status write clears the bits written as 1, but only among bits 6:0. Status bit 7 is 1 after reset and is cleared by any command write with bit 0 clear.
- R11: If a completion and a status write clearing bit 6 fall in the same cycle, bit 6 ends set.
- R12: If a register write to the address or the count falls in the same cycle as a data-port access, the register write decides that register's new value. The access itself and the update of the other register still happen.
- R13: After reset, the command register reads 0x01, the address, count and mask read 0, and status reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| dp_wr | input | 1 | Data-port write strobe |
| dp_rd | input | 1 | Data-port read strobe (ignored while `dp_wr` is high) |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data |
| dp_rvalid | output | 1 | Read data valid |
| cfg_word | input | 1 | 1 = word accesses, 0 = byte accesses |
| ring_start_pg | input | 8 | Ring start page (address bits 15:8) |
| ring_stop_pg | input | 8 | Ring stop page, exclusive |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 2 | Memory byte-lane enables |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after a read |
| irq | output | 1 | Interrupt request |

## Verification
The clash that matters is a data-port access that ends the transfer, landing in the same cycle as a host write to the status register that clears the completion flag. The bench raises both strobes between the same pair of falling edges on a transfer with a count of 1. It then reads the status and expects bit 6 still set, with the interrupt still high. A second clash is a load of the address low byte during a port write. There the bench expects the loaded byte, the old high byte, the written memory byte and a lowered count.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
package rdma_pkg;
  localparam int unsigned ADR_W   = 16;
  localparam int unsigned PG_W    = 8;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = 2;
  localparam int unsigned DAT_W   = BYTE_W * LANES;

  typedef enum logic [REG_AW-1:0] {
    RG_CMD    = 3'd0,
    RG_ADR_LO = 3'd1,
    RG_ADR_HI = 3'd2,
    RG_CNT_LO = 3'd3,
    RG_CNT_HI = 3'd4,
    RG_STAT   = 3'd5,
    RG_MASK   = 3'd6
  } rdma_reg_e;

  localparam int unsigned CMD_HALT_BIT = 0;
  localparam int unsigned CMD_RREQ_BIT = 3;
  localparam int unsigned CMD_WREQ_BIT = 4;
  localparam int unsigned ST_DONE_BIT  = 6;
  localparam int unsigned ST_RST_BIT   = 7;

  localparam logic [BYTE_W-1:0] CMD_RST_VAL  = 8'h01;
  localparam logic [BYTE_W-1:0] STAT_RST_VAL = 8'h80;
  localparam logic [BYTE_W-1:0] IRQ_KEEP     = 8'h7F;
endpackage

// File: rtl/rdma_ptr_unit.sv
`timescale 1ns/1ps
module rdma_ptr_unit
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_adr_lo,
  input  logic              ld_adr_hi,
  input  logic              ld_cnt_lo,
  input  logic              ld_cnt_hi,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              step_en,
  input  logic              step_word,
  input  logic [PG_W-1:0]   ring_start_pg,
  input  logic [PG_W-1:0]   ring_stop_pg,
  output logic [ADR_W-1:0]  cur_adr,
  output logic [ADR_W-1:0]  cur_cnt,
  output logic              cnt_zero,
  output logic              done_pulse
);
  localparam int unsigned OFS = ADR_W - PG_W;

  logic [ADR_W-1:0] wdt, adr_inc, adr_adv, cnt_adv, adr_d, cnt_d;
  logic [ADR_W-1:0] start_adr, stop_adr;
  logic             cnt_last, ld_adr, ld_cnt, adr_en, cnt_en;

  assign start_adr = {ring_start_pg, {OFS{1'b0}}};
  assign stop_adr  = {ring_stop_pg,  {OFS{1'b0}}};

  always_comb begin
    wdt      = step_word ? ADR_W'(2) : ADR_W'(1);
    adr_inc  = cur_adr + wdt;
    adr_adv  = (adr_inc == stop_adr) ? start_adr : adr_inc;
    cnt_last = (cur_cnt <= wdt);
    cnt_adv  = cnt_last ? '0 : (cur_cnt - wdt);
    ld_adr   = ld_adr_lo | ld_adr_hi;
    ld_cnt   = ld_cnt_lo | ld_cnt_hi;
    adr_d    = ld_adr ? cur_adr : adr_adv;
    if (ld_adr_lo) adr_d[BYTE_W-1:0]     = ld_byte;
    if (ld_adr_hi) adr_d[ADR_W-1:BYTE_W] = ld_byte;
    cnt_d    = ld_cnt ? cur_cnt : cnt_adv;
    if (ld_cnt_lo) cnt_d[BYTE_W-1:0]     = ld_byte;
    if (ld_cnt_hi) cnt_d[ADR_W-1:BYTE_W] = ld_byte;
    adr_en   = step_en | ld_adr;
    cnt_en   = step_en | ld_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_adr <= '0;
    end else if (adr_en) begin
      cur_adr <= adr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cnt <= '0;
    end else if (cnt_en) begin
      cur_cnt <= cnt_d;
    end
  end

  assign cnt_zero   = (cur_cnt == '0);
  assign done_pulse = step_en & cnt_last;

  // R4: an access never raises the count
  a_r4_count_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ld_cnt_lo && !ld_cnt_hi) |=> (cur_cnt < $past(cur_cnt) || cur_cnt == '0));

  // R12: a byte load keeps the other address byte
  a_r12_lo_load_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_adr_lo && !ld_adr_hi) |=> cur_adr[ADR_W-1:BYTE_W] == $past(cur_adr[ADR_W-1:BYTE_W]));
endmodule

// File: rtl/rdma_mem_if.sv
`timescale 1ns/1ps
module rdma_mem_if
  import rdma_pkg::*;
#(
  parameter int unsigned LO_END  = 32,
  parameter int unsigned HI_BASE = 16384,
  parameter int unsigned HI_END  = 49152
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic               acc_word,
  input  logic [ADR_W-1:0]   acc_adr,
  input  logic [DAT_W-1:0]   wr_data,
  output logic               mem_en,
  output logic               mem_we,
  output logic [LANES-1:0]   mem_be,
  output logic [ADR_W-2:0]   mem_addr,
  output logic [DAT_W-1:0]   mem_wdata,
  input  logic [DAT_W-1:0]   mem_rdata,
  output logic [DAT_W-1:0]   rd_data,
  output logic               rd_valid
);
  logic [ADR_W-1:0] eff_adr;
  logic             in_win;
  logic             rv_q, oob_q, word_q, lane_q;

  assign eff_adr = acc_word ? {acc_adr[ADR_W-1:1], 1'b0} : acc_adr;
  assign in_win  = (32'(eff_adr) < LO_END) ||
                   ((32'(eff_adr) >= HI_BASE) && (32'(eff_adr) < HI_END));

  assign mem_en   = (acc_rd | acc_wr) & in_win;
  assign mem_we   = acc_wr & in_win;
  assign mem_addr = eff_adr[ADR_W-1:1];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign mem_be[ln] = acc_word | (eff_adr[0] == 1'(ln));
    assign mem_wdata[ln*BYTE_W +: BYTE_W] =
      acc_word ? wr_data[ln*BYTE_W +: BYTE_W] : wr_data[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
    end else begin
      rv_q <= acc_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oob_q  <= 1'b0;
      word_q <= 1'b0;
      lane_q <= 1'b0;
    end else if (acc_rd) begin
      oob_q  <= ~in_win;
      word_q <= acc_word;
      lane_q <= eff_adr[0];
    end
  end

  always_comb begin
    if (!rv_q) begin
      rd_data = '0;
    end else if (oob_q) begin
      rd_data = word_q ? {DAT_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    end else if (word_q) begin
      rd_data = mem_rdata;
    end else begin
      rd_data = {{BYTE_W{1'b0}}, lane_q ? mem_rdata[DAT_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0]};
    end
  end
  assign rd_valid = rv_q;

  // R6: an out-of-window read yields all ones in the next cycle
  a_r6_oob_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !mem_en && acc_word) |=> rd_data == {DAT_W{1'b1}});
endmodule

// File: rtl/rdma_irq_unit.sv
`timescale 1ns/1ps
module rdma_irq_unit
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_set,
  input  logic              run_cmd,
  input  logic              stat_wr,
  input  logic              mask_wr,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] mask,
  output logic              irq
);
  logic [BYTE_W-1:0] status_d;
  logic              status_en;

  always_comb begin
    status_d = status;
    if (stat_wr) status_d = status & ~(wbyte & IRQ_KEEP);
    if (run_cmd) status_d[ST_RST_BIT] = 1'b0;
    if (done_set) status_d[ST_DONE_BIT] = 1'b1;
    status_en = stat_wr | run_cmd | done_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= STAT_RST_VAL;
    end else if (status_en) begin
      status <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (mask_wr) begin
      mask <= wbyte;
    end
  end

  assign irq = |(status & mask & IRQ_KEEP);

  // R11: completion beats a same-cycle clear
  a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done_set && stat_wr && wbyte[ST_DONE_BIT]) |=> status[ST_DONE_BIT]);

  // R10: status writes never touch the top bit
  a_r10_top_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !run_cmd) |=> status[ST_RST_BIT] == $past(status[ST_RST_BIT]));
endmodule

// File: rtl/rdma_port_engine.sv
`timescale 1ns/1ps
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int unsigned LO_END  = 32,
  parameter int unsigned HI_BASE = 16384,
  parameter int unsigned HI_END  = 49152
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              dp_wr,
  input  logic              dp_rd,
  input  logic [DAT_W-1:0]  dp_wdata,
  output logic [DAT_W-1:0]  dp_rdata,
  output logic              dp_rvalid,
  input  logic              cfg_word,
  input  logic [PG_W-1:0]   ring_start_pg,
  input  logic [PG_W-1:0]   ring_stop_pg,
  output logic              mem_en,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [ADR_W-2:0]  mem_addr,
  output logic [DAT_W-1:0]  mem_wdata,
  input  logic [DAT_W-1:0]  mem_rdata,
  output logic              irq
);
  logic              rst_meta, rst_q;
  logic [BYTE_W-1:0] cmd_q, status, mask;
  logic [ADR_W-1:0]  cur_adr, cur_cnt;
  logic              cnt_zero, done_pulse;
  logic              wr_cmd, wr_adr_lo, wr_adr_hi, wr_cnt_lo, wr_cnt_hi, wr_stat, wr_mask;
  logic              run_cmd, zero_go, acc_wr, acc_rd, step_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  always_comb begin
    wr_cmd    = reg_wr && (reg_addr == RG_CMD);
    wr_adr_lo = reg_wr && (reg_addr == RG_ADR_LO);
    wr_adr_hi = reg_wr && (reg_addr == RG_ADR_HI);
    wr_cnt_lo = reg_wr && (reg_addr == RG_CNT_LO);
    wr_cnt_hi = reg_wr && (reg_addr == RG_CNT_HI);
    wr_stat   = reg_wr && (reg_addr == RG_STAT);
    wr_mask   = reg_wr && (reg_addr == RG_MASK);
    run_cmd   = wr_cmd && !reg_wdata[CMD_HALT_BIT];
    zero_go   = run_cmd && cnt_zero &&
                (reg_wdata[CMD_RREQ_BIT] || reg_wdata[CMD_WREQ_BIT]);
    acc_wr    = dp_wr && !cnt_zero;
    acc_rd    = dp_rd && !dp_wr;
    step_en   = acc_wr || acc_rd;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cmd_q <= CMD_RST_VAL;
    end else if (wr_cmd) begin
      cmd_q <= reg_wdata;
    end
  end

  rdma_ptr_unit u_ptr (
    .clk           (clk),
    .rst_n         (rst_q),
    .ld_adr_lo     (wr_adr_lo),
    .ld_adr_hi     (wr_adr_hi),
    .ld_cnt_lo     (wr_cnt_lo),
    .ld_cnt_hi     (wr_cnt_hi),
    .ld_byte       (reg_wdata),
    .step_en       (step_en),
    .step_word     (cfg_word),
    .ring_start_pg (ring_start_pg),
    .ring_stop_pg  (ring_stop_pg),
    .cur_adr       (cur_adr),
    .cur_cnt       (cur_cnt),
    .cnt_zero      (cnt_zero),
    .done_pulse    (done_pulse)
  );

  rdma_mem_if #(.LO_END(LO_END), .HI_BASE(HI_BASE), .HI_END(HI_END)) u_mem (
    .clk       (clk),
    .rst_n     (rst_q),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_word  (cfg_word),
    .acc_adr   (cur_adr),
    .wr_data   (dp_wdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .rd_data   (dp_rdata),
    .rd_valid  (dp_rvalid)
  );

  rdma_irq_unit u_irq (
    .clk      (clk),
    .rst_n    (rst_q),
    .done_set (done_pulse | zero_go),
    .run_cmd  (run_cmd),
    .stat_wr  (wr_stat),
    .mask_wr  (wr_mask),
    .wbyte    (reg_wdata),
    .status   (status),
    .mask     (mask),
    .irq      (irq)
  );

  always_comb begin
    case (reg_addr)
      RG_CMD:    reg_rdata = cmd_q;
      RG_ADR_LO: reg_rdata = cur_adr[BYTE_W-1:0];
      RG_ADR_HI: reg_rdata = cur_adr[ADR_W-1:BYTE_W];
      RG_CNT_LO: reg_rdata = cur_cnt[BYTE_W-1:0];
      RG_CNT_HI: reg_rdata = cur_cnt[ADR_W-1:BYTE_W];
      RG_STAT:   reg_rdata = status;
      RG_MASK:   reg_rdata = mask;
      default:   reg_rdata = '0;
    endcase
  end

  // R5: a port write with no bytes left never reaches memory
  a_r5_zero_count_blocks_write: assert property (@(posedge clk) disable iff (!rst_q)
    (dp_wr && cnt_zero) |-> !mem_we);

  // R8: read data is flagged one cycle after the strobe
  a_r8_read_returns_next: assert property (@(posedge clk) disable iff (!rst_q)
    (dp_rd && !dp_wr) |=> dp_rvalid);

  // R4: the last access of a transfer raises the completion flag
  a_r4_done_flags_status: assert property (@(posedge clk) disable iff (!rst_q)
    done_pulse |=> status[ST_DONE_BIT]);

  // R9: a start request on an empty count completes at once
  a_r9_zero_len_done: assert property (@(posedge clk) disable iff (!rst_q)
    zero_go |=> status[ST_DONE_BIT]);
endmodule

// File: tb/rdma_port_engine_tb.sv
`timescale 1ns/1ps
module rdma_port_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        dp_wr = 1'b0, dp_rd = 1'b0;
  logic [15:0] dp_wdata = '0;
  logic [15:0] dp_rdata;
  logic        dp_rvalid;
  logic        cfg_word = 1'b0;
  logic [7:0]  ring_start_pg = 8'h40, ring_stop_pg = 8'h80;
  logic        mem_en, mem_we, irq;
  logic [1:0]  mem_be;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int total = 0, bad = 0, mem_writes = 0;
  bit done_flag = 0;
  logic [7:0] ram [int];

  always #2.5 clk = ~clk;

  rdma_port_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_wr(dp_wr), .dp_rd(dp_rd),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .dp_rvalid(dp_rvalid),
    .cfg_word(cfg_word), .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq));

  function automatic logic [7:0] rb(int a);
    return ram.exists(a) ? ram[a] : 8'h00;
  endfunction

  function automatic bit backed(int a);
    return (a < 32) || (a >= 16384 && a < 49152);
  endfunction

  // memory model: one-cycle read latency, byte lanes
  always @(posedge clk) begin
    if (mem_en) begin
      int base;
      base = int'(mem_addr) * 2;
      if (mem_we) begin
        mem_writes++;
        if (!backed(base)) begin
          total++; bad++;
          $display("FAIL R6: write reached unbacked address %0d (expected none)", base);
        end
        if (mem_be[0]) ram[base]   = mem_wdata[7:0];
        if (mem_be[1]) ram[base+1] = mem_wdata[15:8];
      end else begin
        mem_rdata <= {rb(base+1), rb(base)};
      end
    end
  end

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk_reg(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] v;
    reg_read(a, v);
    check(req, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic set_xfer(logic [15:0] adr, logic [15:0] cnt);
    reg_write(3'd1, adr[7:0]); reg_write(3'd2, adr[15:8]);
    reg_write(3'd3, cnt[7:0]); reg_write(3'd4, cnt[15:8]);
    reg_write(3'd5, 8'h7F);
  endtask

  task automatic dp_write(logic [15:0] d);
    @(negedge clk); dp_wr = 1'b1; dp_wdata = d;
    @(negedge clk); dp_wr = 1'b0;
  endtask

  task automatic dp_read(string req, logic [15:0] exp);
    @(negedge clk); dp_rd = 1'b1;
    @(negedge clk); dp_rd = 1'b0; #1;
    check({req, "/R8 valid"}, {15'd0, dp_rvalid}, 16'd1);
    check(req, dp_rdata, exp);
    @(negedge clk); #1;
    check("R8 valid drops", {15'd0, dp_rvalid}, 16'd0);
  endtask

  task automatic chk_adr(string req, logic [15:0] exp);
    logic [7:0] lo, hi;
    reg_read(3'd1, lo); reg_read(3'd2, hi);
    check(req, {hi, lo}, exp);
  endtask

  task automatic chk_cnt(string req, logic [15:0] exp);
    logic [7:0] lo, hi;
    reg_read(3'd3, lo); reg_read(3'd4, hi);
    check(req, {hi, lo}, exp);
  endtask

  task automatic t_r13_reset;
    chk_reg("R13 cmd", 3'd0, 8'h01);
    chk_reg("R13 status", 3'd5, 8'h80);
    chk_reg("R13 mask", 3'd6, 8'h00);
    chk_adr("R13 address", 16'h0000);
    chk_cnt("R13 count", 16'h0000);
    check("R13 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_r10_status;
    reg_write(3'd6, 8'hFF);
    check("R10 top bit masked from irq", {15'd0, irq}, 16'd0);
    reg_write(3'd5, 8'h80);
    chk_reg("R10 top bit survives status write", 3'd5, 8'h80);
    reg_write(3'd0, 8'h22);
    chk_reg("R10 run command clears top bit, no R9 set", 3'd5, 8'h00);
    reg_write(3'd6, 8'h00);
  endtask

  task automatic t_r1_loads;
    reg_write(3'd1, 8'h34); reg_write(3'd2, 8'h12);
    chk_adr("R1 address load", 16'h1234);
    reg_write(3'd1, 8'h56);
    chk_adr("R1 low load keeps high", 16'h1256);
    reg_write(3'd3, 8'hAB); reg_write(3'd4, 8'hCD);
    reg_write(3'd4, 8'h01);
    chk_cnt("R1 high load keeps low", 16'h01AB);
    reg_write(3'd6, 8'h5A);
    chk_reg("R1 mask readback", 3'd6, 8'h5A);
  endtask

  task automatic t_r9_zero_len;
    set_xfer(16'h4000, 16'h0000);
    reg_write(3'd6, 8'h40);
    reg_write(3'd0, 8'h09);
    chk_reg("R9 halted request sets nothing", 3'd5, 8'h00);
    reg_write(3'd0, 8'h0A);
    chk_reg("R9 zero-length read request", 3'd5, 8'h40);
    check("R10 irq on done", {15'd0, irq}, 16'd1);
    reg_write(3'd5, 8'h40);
    check("R10 irq after clear", {15'd0, irq}, 16'd0);
    reg_write(3'd0, 8'h12);
    chk_reg("R9 zero-length write request", 3'd5, 8'h40);
    reg_write(3'd6, 8'h00);
  endtask

  task automatic t_r2_bytes;
    int wc;
    cfg_word = 1'b0;
    set_xfer(16'h4000, 16'd3);
    dp_write(16'h00A1); dp_write(16'h00B2);
    chk_reg("R4 not done mid transfer", 3'd5, 8'h00);
    dp_write(16'h00C3);
    check("R2 byte store 0", {8'h00, rb(16'h4000)}, 16'h00A1);
    check("R2 byte store 2", {8'h00, rb(16'h4002)}, 16'h00C3);
    chk_adr("R2 byte step", 16'h4003);
    chk_cnt("R4 count zero", 16'h0000);
    chk_reg("R4 done set", 3'd5, 8'h40);
    wc = mem_writes;
    dp_write(16'h00EE);
    check("R5 no memory write at zero", 16'(mem_writes), 16'(wc));
    chk_adr("R5 address kept", 16'h4003);
    set_xfer(16'h4000, 16'd3);
    dp_read("R2 byte read 0", 16'h00A1);
    dp_read("R7 byte read odd lane", 16'h00B2);
    dp_read("R2 byte read 2", 16'h00C3);
    chk_reg("R4 done on read", 3'd5, 8'h40);
    dp_read("R5 read at zero count", 16'h0000);
    chk_adr("R5 read advances at zero", 16'h4004);
  endtask

  task automatic t_r7_words;
    cfg_word = 1'b1;
    set_xfer(16'h4011, 16'd5);
    dp_write(16'hBEEF);
    check("R7 even byte low", {8'h00, rb(16'h4010)}, 16'h00EF);
    check("R7 odd byte high", {8'h00, rb(16'h4011)}, 16'h00BE);
    chk_adr("R2 word step", 16'h4013);
    chk_cnt("R4 count minus two", 16'd3);
    dp_write(16'h1234);
    chk_cnt("R4 count one left", 16'd1);
    chk_reg("R4 not done with one left", 3'd5, 8'h00);
    dp_write(16'h5678);
    chk_cnt("R4 short tail ends", 16'd0);
    chk_reg("R4 short tail done", 3'd5, 8'h40);
    set_xfer(16'h4010, 16'd4);
    dp_read("R7 word read 0", 16'hBEEF);
    dp_read("R7 word read 1", 16'h1234);
    cfg_word = 1'b0;
  endtask

  task automatic t_r3_wrap;
    ring_start_pg = 8'h40; ring_stop_pg = 8'h42;
    cfg_word = 1'b1;
    set_xfer(16'h41FE, 16'd6);
    dp_write(16'h1111);
    chk_adr("R3 word wrap to start", 16'h4000);
    dp_write(16'h2222);
    chk_adr("R3 after wrap", 16'h4002);
    check("R3 wrapped data", {8'h00, rb(16'h4000)}, 16'h0022);
    cfg_word = 1'b0;
    set_xfer(16'h41FF, 16'd2);
    dp_write(16'h0033);
    chk_adr("R3 byte wrap to start", 16'h4000);
    ring_stop_pg = 8'h80;
  endtask

  task automatic t_r6_windows;
    int wc;
    cfg_word = 1'b0;
    set_xfer(16'h0100, 16'd4);
    dp_read("R6 byte read outside", 16'h00FF);
    wc = mem_writes;
    dp_write(16'h0077);
    check("R6 write outside dropped", 16'(mem_writes), 16'(wc));
    chk_adr("R6 address still advances", 16'h0102);
    chk_cnt("R6 count still drops", 16'd2);
    set_xfer(16'h3FFF, 16'd2);
    wc = mem_writes;
    dp_write(16'h0044);
    check("R6 edge below high window", 16'(mem_writes), 16'(wc));
    set_xfer(16'hBFFF, 16'd2);
    dp_write(16'h0055);
    check("R6 last backed byte", {8'h00, rb(16'hBFFF)}, 16'h0055);
    cfg_word = 1'b1;
    set_xfer(16'hC000, 16'd2);
    dp_read("R6 word read outside", 16'hFFFF);
    set_xfer(16'h001F, 16'd2);
    dp_write(16'hCAFE);
    check("R6 low window word", {rb(16'h001F), rb(16'h001E)}, 16'hCAFE);
    cfg_word = 1'b0;
  endtask

  task automatic t_r11_collision;
    cfg_word = 1'b0;
    set_xfer(16'h4100, 16'd1);
    reg_write(3'd6, 8'h40);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = 16'h0099;
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h40;
    @(negedge clk);
    dp_wr = 1'b0; reg_wr = 1'b0;
    chk_reg("R11 completion survives clear", 3'd5, 8'h40);
    check("R11 irq held", {15'd0, irq}, 16'd1);
    reg_write(3'd6, 8'h00);
  endtask

  task automatic t_r12_load_vs_access;
    cfg_word = 1'b0;
    set_xfer(16'h4020, 16'd4);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = 16'h0066;
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h80;
    @(negedge clk);
    dp_wr = 1'b0; reg_wr = 1'b0;
    chk_adr("R12 load wins address", 16'h4080);
    chk_cnt("R12 count still steps", 16'd3);
    check("R12 access still stores", {8'h00, rb(16'h4020)}, 16'h0066);
  endtask

  initial begin
    #(5 * 100000);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_r13_reset();
    t_r10_status();
    t_r1_loads();
    t_r9_zero_len();
    t_r2_bytes();
    t_r7_words();
    t_r3_wrap();
    t_r6_windows();
    t_r11_collision();
    t_r12_load_vs_access();
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule